// File: doc/BRIEF.md
# USB Low-Speed Packet Receiver

This block turns the two single-ended USB data lines, sampled at a fixed system-clock multiple of the low-speed bit rate, into received packets. It brings both lines into the clock domain through two flops each. It hunts for the sync field and takes the bit phase from the sync edges. It then decodes NRZI, drops stuffed bits and assembles bytes least-significant bit first. The first byte is the packet identifier; every later byte goes out as a data strobe.

When the packet ends, one strobe carries exactly one verdict: good, CRC error, stuff error, overflow or identifier error. The identifier is checked for its nibble complement. Data bytes, including the two CRC bytes, are checked by a reflected CRC16 that must leave the fixed residue 0xB001. Downstream endpoint logic drops a packet on any verdict except good. The default of 12 clocks per bit matches an 18 MHz clock at 1.5 Mbit/s.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset every strobe and flag output is low and the receiver waits for line state K. Line states are {dp,dm}: J = 01 (idle), K = 10, SE0 = 00.
- R2: Each bit lasts CLKS_PER_BIT clocks. During the hunt, the bit phase restarts at every line change, and each bit is sampled half a bit after the last change. Two consecutive K samples end the sync field (K J K J K J K K).
- R3: Bits decode as 1 when the sampled state equals the previous sample and as 0 when it differs, starting from K at the end of sync. The first 8 decoded bits, LSB first, appear on pid_o with a one-cycle pid_valid_o.
- R4: A run of six decoded 1s is counted with the final sync bit as the first of the run. The bit after such a run is dropped if it is a 0. If it is a 1, the packet aborts with eop_o and stuff_err_o.
- R5: At the end of a packet, pid_err_o is raised instead of any other verdict if no complete identifier was received, or if pid[7:4] is not the bitwise inverse of pid[3:0].
- R6: Each complete byte after the identifier, the CRC bytes included, appears on data_o with a one-cycle data_valid_o.
- R7: An SE0 sample after sync ends the packet with an eop_o pulse. Decoded bits of an unfinished byte are discarded.
- R8: A packet with a valid identifier and no data bytes ends with good_o. With data bytes, a CRC16 is run over all of them: polynomial 0xA001 in reflected form, LSB first, starting at 0xFFFF. The packet ends with good_o if the result is 0xB001 and with crc_err_o otherwise.
- R9: The data byte that would exceed MAX_BYTES is not output. The same byte immediately produces eop_o with ovf_err_o.
- R10: Each eop_o carries exactly one of good_o, crc_err_o, stuff_err_o, ovf_err_o, pid_err_o, and no flag is raised without eop_o.
- R11: If sync has not ended within 3 bit times of the last J-to-K change, the receiver returns to idle without any output.
- R12: After an end or an abort, the line is ignored until an SE0 sample and then a J sample are seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, CLKS_PER_BIT per bit |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dp_i | input | 1 | D+ line, asynchronous |
| dm_i | input | 1 | D- line, asynchronous |
| pid_o | output | 8 | Last received packet identifier |
| pid_valid_o | output | 1 | Identifier strobe |
| data_o | output | 8 | Received data byte |
| data_valid_o | output | 1 | Data byte strobe |
| eop_o | output | 1 | End-of-packet strobe |
| good_o | output | 1 | Packet accepted |
| crc_err_o | output | 1 | CRC residue mismatch |
| stuff_err_o | output | 1 | Missing transition after six 1s |
| ovf_err_o | output | 1 | Too many data bytes |
| pid_err_o | output | 1 | Identifier missing or not complemented |

## Verification
The assertions check on every cycle the properties that need no packet history:
- a verdict always comes with an end strobe, and there is exactly one verdict per end;
- strobes never coincide;
- an abort or an SE0 sample is followed by the waiting state;
- the hunt timer stays within its limit.

Only the scenarios can show that bit decoding, stuffing removal, identifier and CRC checks and the overflow cut-off are correct. For this, the bench builds NRZI frames from its own encoder and CRC, and checks the byte stream and verdict of each one. The same holds for the timeout after a lone K, dribble bits before SE0, and input ignored after an abort; for these, the check is that no unexpected strobe appears.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HUNT,
    ST_DATA,
    ST_WAIT
  } rx_state_e;

  localparam logic [15:0] CRC_POLY    = 16'hA001;
  localparam logic [15:0] CRC_INIT    = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE = 16'hB001;

  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/usb_ls_line_sync.sv
module usb_ls_line_sync
  import usb_ls_rx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  dp_i,
  input  logic  dm_i,
  output line_e line_o
);

  logic [1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= LS_J;
      s2_q <= LS_J;
    end else begin
      s1_q <= {dp_i, dm_i};
      s2_q <= s1_q;
    end
  end

  assign line_o = line_e'(s2_q);

endmodule

// File: rtl/usb_ls_bit_rx.sv
module usb_ls_bit_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 12
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  line_e line_i,
  input  logic  abort_i,
  output logic  bit_vld_o,
  output logic  bit_o,
  output logic  se0_o,
  output logic  stuff_err_o
);

  localparam int PW  = $clog2(CLKS_PER_BIT);
  localparam int TMO = 3 * CLKS_PER_BIT;
  localparam int TW  = $clog2(TMO + 1);
  localparam logic [PW-1:0] HALF = PW'(CLKS_PER_BIT / 2);
  localparam logic [PW-1:0] LAST = PW'(CLKS_PER_BIT - 1);

  rx_state_e     st_q;
  line_e         line_q, prev_q;
  logic [PW-1:0] phase_q;
  logic [TW-1:0] tmo_q;
  logic          k_seen_q, seen_se0_q;
  logic [2:0]    ones_q;

  logic sample, line_chg, same, data_smp;

  assign sample   = (phase_q == HALF);
  assign line_chg = (line_i != line_q);
  assign same     = (line_i == prev_q);
  assign data_smp = (st_q == ST_DATA) && sample;

  assign se0_o       = data_smp && (line_i == LS_SE0);
  assign stuff_err_o = data_smp && (line_i != LS_SE0) && (ones_q == 3'd6) && same;
  assign bit_vld_o   = data_smp && (line_i != LS_SE0) && (ones_q != 3'd6);
  assign bit_o       = same;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      line_q     <= LS_J;
      prev_q     <= LS_J;
      phase_q    <= '0;
      tmo_q      <= '0;
      k_seen_q   <= 1'b0;
      seen_se0_q <= 1'b0;
      ones_q     <= '0;
    end else begin
      line_q <= line_i;
      // realign only while hunting or waiting; free-run inside a packet
      if (st_q == ST_IDLE || ((st_q == ST_HUNT || st_q == ST_WAIT) && line_chg) || phase_q == LAST)
        phase_q <= '0;
      else
        phase_q <= phase_q + 1'b1;

      case (st_q)
        ST_IDLE: begin
          if (line_i == LS_K) begin
            st_q     <= ST_HUNT;
            tmo_q    <= '0;
            k_seen_q <= 1'b0;
          end
        end
        ST_HUNT: begin
          if (line_chg && line_i == LS_K) tmo_q <= '0;
          else                            tmo_q <= tmo_q + 1'b1;
          if (tmo_q == TW'(TMO)) begin
            st_q <= ST_IDLE;
          end else if (sample) begin
            if (line_i == LS_SE0) begin
              st_q <= ST_IDLE;
            end else if (line_i == LS_K) begin
              if (k_seen_q) begin
                st_q   <= ST_DATA;
                prev_q <= LS_K;
                ones_q <= 3'd1;
              end
              k_seen_q <= 1'b1;
            end else begin
              k_seen_q <= 1'b0;
            end
          end
        end
        ST_DATA: begin
          if (abort_i) begin
            st_q       <= ST_WAIT;
            seen_se0_q <= 1'b0;
          end else if (sample) begin
            if (line_i == LS_SE0) begin
              st_q       <= ST_WAIT;
              seen_se0_q <= 1'b1;
            end else begin
              prev_q <= line_i;
              if (ones_q == 3'd6) begin
                if (same) begin
                  st_q       <= ST_WAIT;
                  seen_se0_q <= 1'b0;
                end
                ones_q <= '0;
              end else begin
                ones_q <= same ? ones_q + 3'd1 : 3'd0;
              end
            end
          end
        end
        ST_WAIT: begin
          if (sample) begin
            if (line_i == LS_SE0)                 seen_se0_q <= 1'b1;
            else if (line_i == LS_J && seen_se0_q) st_q       <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  stuff_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_err_o |=> (st_q == ST_WAIT));
  // R7
  se0_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    se0_o |=> (st_q == ST_WAIT) && seen_se0_q);
  // R11
  hunt_tmo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HUNT) |-> (tmo_q <= TW'(TMO)));

endmodule

// File: rtl/usb_ls_byte_rx.sv
module usb_ls_byte_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int MAX_BYTES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_vld_i,
  input  logic       bit_i,
  input  logic       se0_i,
  input  logic       stuff_i,
  output logic       abort_o,
  output logic [7:0] pid_o,
  output logic       pid_valid_o,
  output logic [7:0] data_o,
  output logic       data_valid_o,
  output logic       eop_o,
  output logic       good_o,
  output logic       crc_err_o,
  output logic       stuff_err_o,
  output logic       ovf_err_o,
  output logic       pid_err_o
);

  localparam int NW = $clog2(MAX_BYTES + 1);

  logic [7:0]    sr_q;
  logic [2:0]    bcnt_q;
  logic          have_pid_q, pid_ok_q;
  logic [NW-1:0] nbytes_q;
  logic [15:0]   crc_q;

  logic [7:0] byte_n;
  logic       byte_done;

  assign byte_n    = {bit_i, sr_q[7:1]};
  assign byte_done = bit_vld_i && (bcnt_q == 3'd7);
  assign abort_o   = byte_done && have_pid_q && (nbytes_q == NW'(MAX_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0; bcnt_q <= '0; have_pid_q <= 1'b0; pid_ok_q <= 1'b0;
      nbytes_q <= '0; crc_q <= CRC_INIT; pid_o <= '0; data_o <= '0;
      pid_valid_o <= 1'b0; data_valid_o <= 1'b0; eop_o <= 1'b0;
      good_o <= 1'b0; crc_err_o <= 1'b0; stuff_err_o <= 1'b0;
      ovf_err_o <= 1'b0; pid_err_o <= 1'b0;
    end else begin
      pid_valid_o <= 1'b0; data_valid_o <= 1'b0; eop_o <= 1'b0;
      good_o <= 1'b0; crc_err_o <= 1'b0; stuff_err_o <= 1'b0;
      ovf_err_o <= 1'b0; pid_err_o <= 1'b0;
      if (stuff_i || se0_i || abort_o) begin
        eop_o      <= 1'b1;
        have_pid_q <= 1'b0;
        pid_ok_q   <= 1'b0;
        bcnt_q     <= '0;
        nbytes_q   <= '0;
        if (stuff_i)                      stuff_err_o <= 1'b1;
        else if (abort_o)                 ovf_err_o   <= 1'b1;
        else if (!have_pid_q || !pid_ok_q) pid_err_o  <= 1'b1;
        else if (nbytes_q == '0 || crc_q == CRC_RESIDUE) good_o <= 1'b1;
        else                              crc_err_o   <= 1'b1;
      end else if (bit_vld_i) begin
        sr_q   <= byte_n;
        bcnt_q <= bcnt_q + 3'd1;
        if (byte_done) begin
          if (!have_pid_q) begin
            pid_o       <= byte_n;
            pid_valid_o <= 1'b1;
            have_pid_q  <= 1'b1;
            pid_ok_q    <= (byte_n[7:4] == ~byte_n[3:0]);
            crc_q       <= CRC_INIT;
          end else begin
            data_o       <= byte_n;
            data_valid_o <= 1'b1;
            nbytes_q     <= nbytes_q + 1'b1;
            crc_q        <= crc16_byte(crc_q, byte_n);
          end
        end
      end
    end
  end

  // R10
  one_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> ($countones({good_o, crc_err_o, stuff_err_o, ovf_err_o, pid_err_o}) == 1));
  // R10
  flag_needs_eop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (good_o | crc_err_o | stuff_err_o | ovf_err_o | pid_err_o) |-> eop_o);
  // R6
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pid_valid_o, data_valid_o, eop_o}));
  // R9
  ovf_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> (eop_o && ovf_err_o && !data_valid_o));

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 12,
  parameter int MAX_BYTES    = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dp_i,
  input  logic       dm_i,
  output logic [7:0] pid_o,
  output logic       pid_valid_o,
  output logic [7:0] data_o,
  output logic       data_valid_o,
  output logic       eop_o,
  output logic       good_o,
  output logic       crc_err_o,
  output logic       stuff_err_o,
  output logic       ovf_err_o,
  output logic       pid_err_o
);

  line_e line;
  logic  bit_vld, bit_val, se0_evt, stuff_evt, abort;

  usb_ls_line_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .dp_i  (dp_i),
    .dm_i  (dm_i),
    .line_o(line)
  );

  usb_ls_bit_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_bit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line),
    .abort_i    (abort),
    .bit_vld_o  (bit_vld),
    .bit_o      (bit_val),
    .se0_o      (se0_evt),
    .stuff_err_o(stuff_evt)
  );

  usb_ls_byte_rx #(.MAX_BYTES(MAX_BYTES)) u_byte (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_vld_i   (bit_vld),
    .bit_i       (bit_val),
    .se0_i       (se0_evt),
    .stuff_i     (stuff_evt),
    .abort_o     (abort),
    .pid_o       (pid_o),
    .pid_valid_o (pid_valid_o),
    .data_o      (data_o),
    .data_valid_o(data_valid_o),
    .eop_o       (eop_o),
    .good_o      (good_o),
    .crc_err_o   (crc_err_o),
    .stuff_err_o (stuff_err_o),
    .ovf_err_o   (ovf_err_o),
    .pid_err_o   (pid_err_o)
  );

endmodule

// File: tb/usb_ls_rx_tb.sv
`timescale 1ns/1ps
module usb_ls_rx_tb;

  localparam int CPB  = 12;
  localparam int MAXB = 8;
  localparam logic [1:0] J = 2'b01, K = 2'b10, SE0 = 2'b00;
  // verdict encoding {pid_err, ovf, stuff, crc, good}
  localparam logic [7:0] V_GOOD = 8'h01, V_CRC = 8'h02, V_STUFF = 8'h04,
                         V_OVF = 8'h08, V_PID = 8'h10;

  logic clk = 1'b0, rst_n = 1'b0, dp = 1'b0, dm = 1'b1;
  logic [7:0] pid_o, data_o;
  logic pid_valid_o, data_valid_o, eop_o, good_o, crc_err_o, stuff_err_o, ovf_err_o, pid_err_o;

  always #2.5 clk = ~clk;

  usb_ls_rx #(.CLKS_PER_BIT(CPB), .MAX_BYTES(MAXB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dp_i(dp), .dm_i(dm),
    .pid_o(pid_o), .pid_valid_o(pid_valid_o), .data_o(data_o), .data_valid_o(data_valid_o),
    .eop_o(eop_o), .good_o(good_o), .crc_err_o(crc_err_o), .stuff_err_o(stuff_err_o),
    .ovf_err_o(ovf_err_o), .pid_err_o(pid_err_o)
  );

  int n_checks = 0, n_errors = 0;
  int         q_kind[$];
  logic [7:0] q_val[$];
  int         q_req[$];

  task automatic push(input int kind, input logic [7:0] val, input int req);
    q_kind.push_back(kind); q_val.push_back(val); q_req.push_back(req);
  endtask

  task automatic got(input int kind, input logic [7:0] val);
    int ek, er; logic [7:0] ev;
    n_checks++;
    if (q_kind.size() == 0) begin
      n_errors++;
      $display("FAIL R%0d: unexpected event kind %0d value %02h, expected none",
               (kind == 0) ? 3 : (kind == 1) ? 6 : 10, kind, val);
    end else begin
      ek = q_kind.pop_front(); ev = q_val.pop_front(); er = q_req.pop_front();
      if (ek != kind || ev != val) begin
        n_errors++;
        $display("FAIL R%0d: got kind %0d value %02h, expected kind %0d value %02h",
                 er, kind, val, ek, ev);
      end
    end
  endtask

  // monitor: kinds 0 = identifier, 1 = data byte, 2 = end verdict
  always @(negedge clk) begin
    if (rst_n) begin
      if (pid_valid_o)  got(0, pid_o);
      if (data_valid_o) got(1, data_o);
      if (eop_o)        got(2, {3'b0, pid_err_o, ovf_err_o, stuff_err_o, crc_err_o, good_o});
    end
  end

  // ---------------- line driver ----------------
  logic [1:0] cur_ls = J;
  int ones = 0;

  task automatic send_ls(input logic [1:0] ls);
    {dp, dm} = ls;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic tx_bit(input logic b);
    if (!b) cur_ls = (cur_ls == J) ? K : J;
    send_ls(cur_ls);
  endtask

  task automatic tx_sbit(input logic b);
    tx_bit(b);
    ones = b ? ones + 1 : 0;
    if (ones == 6) begin tx_bit(1'b0); ones = 0; end
  endtask

  task automatic tx_sync();
    cur_ls = J;
    for (int i = 0; i < 7; i++) tx_bit(1'b0);
    tx_bit(1'b1);
    ones = 1;
  endtask

  task automatic tx_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) tx_sbit(b[i]);
  endtask

  task automatic tx_eop();
    send_ls(SE0); send_ls(SE0); cur_ls = J; send_ls(J);
    repeat (3) send_ls(J);
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r = r ^ 16'hA001;
    end
    return r;
  endfunction

  task automatic drain(input int req);
    repeat (4 * CPB) @(negedge clk);
    n_checks++;
    if (q_kind.size() != 0) begin
      n_errors++;
      $display("FAIL R%0d: %0d expected events missing, expected 0", req, q_kind.size());
      q_kind.delete(); q_val.delete(); q_req.delete();
    end
  endtask

  logic [7:0] pay [0:15];

  // data packet: payload n bytes + CRC; corrupt flips a CRC bit; dribble adds partial bits
  task automatic send_data(input logic [7:0] pid, input int n, input logic corrupt,
                           input int dribble, input int req);
    logic [15:0] c = 16'hFFFF;
    logic [7:0]  fr [0:17];
    int total = n + 2;
    for (int i = 0; i < n; i++) begin fr[i] = pay[i]; c = ref_crc(c, pay[i]); end
    fr[n]   = ~c[7:0] ^ {7'b0, corrupt};
    fr[n+1] = ~c[15:8];
    push(0, pid, 3);
    for (int i = 0; i < total && i < MAXB; i++) push(1, fr[i], 6);
    if (total > MAXB) push(2, V_OVF, 9);
    else              push(2, corrupt ? V_CRC : V_GOOD, req);
    tx_sync();
    tx_byte(pid);
    for (int i = 0; i < total; i++) tx_byte(fr[i]);
    for (int i = 0; i < dribble; i++) tx_sbit(i[0]);
    tx_eop();
    drain(req);
  endtask

  initial begin
    repeat (1000 * CPB) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    n_checks++;
    if ({pid_valid_o, data_valid_o, eop_o, good_o, crc_err_o, stuff_err_o, ovf_err_o, pid_err_o} != 8'h00) begin
      n_errors++;
      $display("FAIL R1: strobes %b after reset, expected 00000000",
               {pid_valid_o, data_valid_o, eop_o, good_o, crc_err_o, stuff_err_o, ovf_err_o, pid_err_o});
    end
    repeat (2) send_ls(J);

    // R2 R3 R8: handshake, identifier only
    push(0, 8'hD2, 3); push(2, V_GOOD, 8);
    tx_sync(); tx_byte(8'hD2); tx_eop(); drain(2);

    // R6 R8: data packet with good CRC
    pay[0] = 8'h01; pay[1] = 8'h02; pay[2] = 8'h03;
    send_data(8'hC3, 3, 1'b0, 0, 8);

    // R8: corrupted CRC
    send_data(8'h4B, 3, 1'b1, 0, 8);

    // R4: stuffing inside all-ones payload
    pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'h7E; pay[3] = 8'h3F;
    send_data(8'hC3, 4, 1'b0, 0, 4);

    // R8: empty payload, CRC bytes only
    send_data(8'h4B, 0, 1'b0, 0, 8);

    // R7: three dribble bits before SE0
    pay[0] = 8'hA5; pay[1] = 8'h5A;
    send_data(8'hC3, 2, 1'b0, 3, 7);

    // R9 boundary: exactly MAX_BYTES data bytes accepted
    for (int i = 0; i < 6; i++) pay[i] = 8'(8'h10 + i);
    send_data(8'h4B, 6, 1'b0, 0, 9);

    // R9 R12: one byte too many, rest of frame ignored
    for (int i = 0; i < 7; i++) pay[i] = 8'(8'h20 + i);
    send_data(8'hC3, 7, 1'b0, 0, 12);

    // R5: identifier nibbles not complementary
    push(0, 8'hC4, 3); push(2, V_PID, 5);
    tx_sync(); tx_byte(8'hC4); tx_eop(); drain(5);

    // R5: SE0 right after sync, no identifier
    push(2, V_PID, 5);
    tx_sync(); tx_eop(); drain(5);

    // R4 R12: missing stuff transition, following bits ignored
    push(0, 8'hD2, 3); push(2, V_STUFF, 4);
    tx_sync(); tx_byte(8'hD2);
    for (int i = 0; i < 7; i++) tx_bit(1'b1);
    ones = 0;
    tx_byte(8'h00); tx_byte(8'h55);
    tx_eop(); drain(12);

    // R11: lone K then idle, nothing reported, next packet still received
    send_ls(K); cur_ls = J;
    repeat (10) send_ls(J);
    drain(11);
    push(0, 8'h5A, 11); push(2, V_GOOD, 11);
    tx_sync(); tx_byte(8'h5A); tx_eop(); drain(11);

    // R10: verdict exclusivity is also covered by every verdict compare above
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule